// File: doc/BRIEF.md
# Segmented LRU Instruction Cache

This block is the instruction store that sits between a fetch unit and instruction memory. It holds 512 bytes as four segments of sixty-four 16-bit words. The program counter addresses bits, and its four low bits carry no information because instructions are 16-bit aligned. Bits 31..10 of the counter form a 22-bit segment base that is compared against each segment's base register. Bits 9..4 pick one word inside the segment. Each word has its own valid flag, so a segment fills one word at a time as the program needs it.

The fetch side holds `fetch_req` with a counter value. When the word is present, `fetch_hit` rises in the same cycle and `fetch_word` carries the instruction. On a miss the controller moves from state LOOKUP to state REFILL and raises a word request towards memory. If no segment carries the base, the least-recently-used segment is first given the new base and all of its words are invalidated. The controller returns from REFILL to LOOKUP on the memory acknowledge, in the same edge that writes the word. The fetch stays pending and then hits. Software takes no part in any of this; only reset empties the cache.

There are two states. LOOKUP goes to REFILL on a requested miss and otherwise stays put. REFILL goes back to LOOKUP on `mem_ack` and otherwise waits.

Top module: `icache_seg_lru`

## Requirements
- R1: After reset no word is valid, `mem_req` is low, and the recency order is segment 0 least recent, then 1, 2, and segment 3 most recent.
- R2: While in LOOKUP, if `fetch_req` is high, some segment's base equals `fetch_pc[31:10]`, and the word at `fetch_pc[9:4]` is valid, then `fetch_hit` is high in that same cycle and `fetch_word` equals the stored word.
- R3: `fetch_pc[3:0]` has no effect on hit, word or refill address.
- R4: A requested miss raises `mem_req` at the next clock edge with `mem_addr = {fetch_pc[31:4], 4'b0000}`. Both are held unchanged until `mem_ack`, and no hit is reported while `mem_req` is high.
- R5: The edge where `mem_req` and `mem_ack` are both high stores `mem_data` and drops `mem_req`. A fetch held on the same counter value hits in the following cycle with that data.
- R6: A miss whose base matches a segment refills that same segment, and that segment's other valid words keep hitting.
- R7: A miss whose base matches no segment gives the least-recently-used segment the new base and invalidates all of its words.
- R8: A hit or a refill write makes the segment used most recent. The segments that ranked above it each move down one place.
- R9: With `fetch_req` low, `fetch_hit` is low and no refill is started.
- R10: No two segments ever match the same counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Fetch request, held until hit |
| fetch_pc | input | 32 | Bit-addressed program counter |
| fetch_hit | output | 1 | Word present this cycle |
| fetch_word | output | 16 | Instruction word |
| mem_req | output | 1 | Refill word request |
| mem_addr | output | 32 | Bit address of requested word |
| mem_ack | input | 1 | Refill data valid |
| mem_data | input | 16 | Refill word |

## Verification
A wrong recency ranking does not show at once. It appears at the next base miss, when the wrong segment is reassigned. From then on, words that should still be resident miss and raise an unexpected `mem_req` on the edge after the fetch. A bad valid flag or base register appears in the same cycle as a wrong `fetch_hit`, and a corrupted refill shows one cycle after the acknowledge as a wrong `fetch_word`. A reference model of bases, valid flags and ranking therefore predicts every hit and miss over long mixed sequences of six bases against four segments.

// File: rtl/icache_pkg.sv
package icache_pkg;
    typedef enum logic {
        ST_LOOKUP = 1'b0,
        ST_REFILL = 1'b1
    } fill_state_e;
endpackage

// File: rtl/icache_tag_match.sv
module icache_tag_match #(
    parameter int SEG_CNT = 4,
    parameter int TAG_W   = 22,
    localparam int SEG_W  = $clog2(SEG_CNT)
) (
    input  logic [SEG_CNT-1:0][TAG_W-1:0] seg_tag,
    input  logic [SEG_CNT-1:0]            seg_live,
    input  logic [TAG_W-1:0]              probe_tag,
    output logic [SEG_CNT-1:0]            match_vec,
    output logic                          match_any,
    output logic [SEG_W-1:0]              match_idx
);
    for (genvar g = 0; g < SEG_CNT; g++) begin : g_cmp
        assign match_vec[g] = seg_live[g] && (seg_tag[g] == probe_tag);
    end

    assign match_any = |match_vec;

    always_comb begin
        match_idx = '0;
        for (int i = 0; i < SEG_CNT; i++) begin
            if (match_vec[i]) match_idx = SEG_W'(i);
        end
    end
endmodule

// File: rtl/icache_lru_rank.sv
module icache_lru_rank #(
    parameter int SEG_CNT = 4,
    localparam int SEG_W  = $clog2(SEG_CNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [SEG_W-1:0] touch_idx,
    output logic [SEG_W-1:0] victim_idx
);
    // rank 0 = least recent, SEG_CNT-1 = most recent
    logic [SEG_W-1:0] rank_q [SEG_CNT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SEG_CNT; i++) rank_q[i] <= SEG_W'(i);
        end else if (touch_en) begin
            for (int i = 0; i < SEG_CNT; i++) begin
                if (SEG_W'(i) == touch_idx)
                    rank_q[i] <= SEG_W'(SEG_CNT - 1);
                else if (rank_q[i] > rank_q[touch_idx])
                    rank_q[i] <= rank_q[i] - 1'b1;
            end
        end
    end

    always_comb begin
        victim_idx = '0;
        for (int i = 0; i < SEG_CNT; i++) begin
            if (rank_q[i] == '0) victim_idx = SEG_W'(i);
        end
    end
endmodule

// File: rtl/icache_word_store.sv
module icache_word_store #(
    parameter int SEG_CNT   = 4,
    parameter int SEG_WORDS = 64,
    parameter int WORD_W    = 16,
    localparam int SEG_W    = $clog2(SEG_CNT),
    localparam int IDX_W    = $clog2(SEG_WORDS),
    localparam int DEPTH    = SEG_CNT * SEG_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic [SEG_W-1:0]  clr_seg,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_seg,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [SEG_W-1:0]  rd_seg,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [WORD_W-1:0]                 word_mem [DEPTH];
    logic [SEG_CNT-1:0][SEG_WORDS-1:0] valid_q;

    always_ff @(posedge clk) begin
        if (wr_en) word_mem[{wr_seg, wr_idx}] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (clr_en) valid_q[clr_seg] <= '0;
            if (wr_en)  valid_q[wr_seg][wr_idx] <= 1'b1;
        end
    end

    assign rd_data  = word_mem[{rd_seg, rd_idx}];
    assign rd_valid = valid_q[rd_seg][rd_idx];
endmodule

// File: rtl/icache_seg_lru.sv
module icache_seg_lru #(
    parameter int ADDR_W    = 32,
    parameter int WORD_W    = 16,
    parameter int SEG_CNT   = 4,
    parameter int SEG_WORDS = 64,
    parameter int LSB_ZERO  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              fetch_hit,
    output logic [WORD_W-1:0] fetch_word,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_data
);
    import icache_pkg::*;

    localparam int SEG_W   = $clog2(SEG_CNT);
    localparam int IDX_W   = $clog2(SEG_WORDS);
    localparam int TAG_LSB = LSB_ZERO + IDX_W;
    localparam int TAG_W   = ADDR_W - TAG_LSB;

    fill_state_e state_q, state_d;

    logic [SEG_CNT-1:0][TAG_W-1:0] seg_tag_q;
    logic [SEG_CNT-1:0]            seg_live_q;
    logic [SEG_W-1:0]              fill_seg_q;
    logic [ADDR_W-1:0]             fill_addr_q;

    logic [TAG_W-1:0]   probe_tag;
    logic [IDX_W-1:0]   probe_idx;
    logic [SEG_CNT-1:0] seg_match;
    logic               seg_any;
    logic [SEG_W-1:0]   seg_idx;
    logic [SEG_W-1:0]   victim_idx;
    logic               rd_valid;
    logic               miss_start;
    logic               alloc_en;
    logic               fill_wr;
    logic               touch_en;
    logic [SEG_W-1:0]   touch_idx;
    logic               unused_pc_lsb;

    assign probe_tag     = fetch_pc[ADDR_W-1:TAG_LSB];
    assign probe_idx     = fetch_pc[TAG_LSB-1:LSB_ZERO];
    assign unused_pc_lsb = ^fetch_pc[LSB_ZERO-1:0];

    icache_tag_match #(.SEG_CNT(SEG_CNT), .TAG_W(TAG_W)) u_match (
        .seg_tag   (seg_tag_q),
        .seg_live  (seg_live_q),
        .probe_tag (probe_tag),
        .match_vec (seg_match),
        .match_any (seg_any),
        .match_idx (seg_idx)
    );

    icache_lru_rank #(.SEG_CNT(SEG_CNT)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .victim_idx (victim_idx)
    );

    icache_word_store #(
        .SEG_CNT(SEG_CNT), .SEG_WORDS(SEG_WORDS), .WORD_W(WORD_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (alloc_en),
        .clr_seg  (victim_idx),
        .wr_en    (fill_wr),
        .wr_seg   (fill_seg_q),
        .wr_idx   (fill_addr_q[TAG_LSB-1:LSB_ZERO]),
        .wr_data  (mem_data),
        .rd_seg   (seg_idx),
        .rd_idx   (probe_idx),
        .rd_data  (fetch_word),
        .rd_valid (rd_valid)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOOKUP;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        fetch_hit  = 1'b0;
        miss_start = 1'b0;
        mem_req    = 1'b0;
        fill_wr    = 1'b0;
        unique case (state_q)
            ST_LOOKUP: begin
                fetch_hit  = fetch_req && seg_any && rd_valid;
                miss_start = fetch_req && !(seg_any && rd_valid);
                if (miss_start) state_d = ST_REFILL;
            end
            ST_REFILL: begin
                mem_req = 1'b1;
                fill_wr = mem_ack;
                if (mem_ack) state_d = ST_LOOKUP;
            end
            default: state_d = ST_LOOKUP;
        endcase
    end

    assign alloc_en  = miss_start && !seg_any;
    assign touch_en  = fetch_hit || fill_wr;
    assign touch_idx = fill_wr ? fill_seg_q : seg_idx;
    assign mem_addr  = fill_addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_live_q  <= '0;
            seg_tag_q   <= '0;
            fill_seg_q  <= '0;
            fill_addr_q <= '0;
        end else if (miss_start) begin
            fill_seg_q  <= seg_any ? seg_idx : victim_idx;
            fill_addr_q <= {fetch_pc[ADDR_W-1:LSB_ZERO], {LSB_ZERO{1'b0}}};
            if (alloc_en) begin
                seg_tag_q[victim_idx]  <= probe_tag;
                seg_live_q[victim_idx] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/icache_seg_lru_chk.sv
module icache_seg_lru_chk #(
    parameter int ADDR_W   = 32,
    parameter int SEG_CNT  = 4,
    parameter int LSB_ZERO = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fetch_req,
    input logic               fetch_hit,
    input logic               mem_req,
    input logic               mem_ack,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [SEG_CNT-1:0] seg_match
);
    p_hit_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hit |-> fetch_req);

    p_no_hit_in_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !fetch_hit);

    p_miss_starts_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_hit && !mem_req) |=> mem_req);

    p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    p_addr_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[LSB_ZERO-1:0] == '0));

    p_req_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req);

    p_idle_no_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_req && !mem_req) |=> !mem_req);

    p_single_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(seg_match));
endmodule

bind icache_seg_lru icache_seg_lru_chk #(
    .ADDR_W(ADDR_W), .SEG_CNT(SEG_CNT), .LSB_ZERO(LSB_ZERO)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_req (fetch_req),
    .fetch_hit (fetch_hit),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .seg_match (seg_match)
);

// File: tb/icache_seg_lru_test.sv
`timescale 1ns/1ps
module icache_seg_lru_test;
    localparam int NSEG = 4;
    localparam int NWRD = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        fetch_hit;
    logic [15:0] fetch_word;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_data = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    icache_seg_lru uut (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_pc(fetch_pc),
        .fetch_hit(fetch_hit), .fetch_word(fetch_word), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data)
    );

    // reference model built from the requirements
    bit [21:0] m_tag   [NSEG];
    bit        m_live  [NSEG];
    bit        m_valid [NSEG][NWRD];
    int        m_rank  [NSEG];
    int unsigned lcg = 32'h1234_5678;

    function automatic logic [15:0] mem_img(logic [31:0] a);
        return a[19:4] ^ {a[27:20], a[27:20]} ^ 16'h3C5A;
    endfunction

    function automatic int find_seg(bit [21:0] t);
        for (int i = 0; i < NSEG; i++) if (m_live[i] && m_tag[i] == t) return i;
        return -1;
    endfunction

    function automatic int lru_seg();
        for (int i = 0; i < NSEG; i++) if (m_rank[i] == 0) return i;
        return 0;
    endfunction

    task automatic m_touch(int s);
        int r = m_rank[s];
        for (int j = 0; j < NSEG; j++) if (m_rank[j] > r) m_rank[j]--;
        m_rank[s] = NSEG - 1;
    endtask

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_pc(int region, int word);
        logic [21:0] t = 22'h15A00 + 22'(region * 37);
        return {t, 6'(word), 4'h0};
    endfunction

    task automatic do_fetch(logic [31:0] pc, int stall);
        bit [21:0] t = pc[31:10];
        int w = int'(pc[9:4]);
        int s = find_seg(t);
        bit exp_hit = (s >= 0) && m_valid[s][w];
        string lbl = exp_hit ? "R2 R8 hit" : ((s >= 0) ? "R6 same-seg miss" : "R7 new-base miss");
        logic [31:0] aligned = {pc[31:4], 4'h0};
        @(negedge clk);
        fetch_req = 1'b1;
        fetch_pc  = pc;
        #1;
        chk(fetch_hit == exp_hit, lbl, 32'(fetch_hit), 32'(exp_hit));
        if (exp_hit) begin
            chk(fetch_word == mem_img(aligned), "R2 word", 32'(fetch_word), 32'(mem_img(aligned)));
            m_touch(s);
        end else begin
            if (s < 0) begin
                s = lru_seg();
                m_tag[s]  = t;
                m_live[s] = 1'b1;
                for (int k = 0; k < NWRD; k++) m_valid[s][k] = 1'b0;
            end
            @(negedge clk);
            chk(mem_req == 1'b1, "R4 request raised", 32'(mem_req), 32'd1);
            chk(mem_addr == aligned, "R4 R3 request address", mem_addr, aligned);
            for (int k = 0; k < stall; k++) begin
                @(negedge clk);
                chk(mem_req == 1'b1 && mem_addr == aligned, "R4 request held", mem_addr, aligned);
            end
            mem_ack  = 1'b1;
            mem_data = mem_img(aligned);
            @(negedge clk);
            mem_ack = 1'b0;
            m_valid[s][w] = 1'b1;
            m_touch(s);
            #1;
            chk(mem_req == 1'b0, "R5 request dropped", 32'(mem_req), 32'd0);
            chk(fetch_hit == 1'b1, "R5 hit after refill", 32'(fetch_hit), 32'd1);
            chk(fetch_word == mem_img(aligned), "R5 refill word", 32'(fetch_word), 32'(mem_img(aligned)));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NSEG; i++) begin
            m_live[i] = 1'b0;
            m_rank[i] = i;
            for (int k = 0; k < NWRD; k++) m_valid[i][k] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_req == 1'b0, "R1 no request after reset", 32'(mem_req), 32'd0);
        fetch_pc = mk_pc(0, 0);
        #1;
        chk(fetch_hit == 1'b0, "R1 empty after reset", 32'(fetch_hit), 32'd0);

        // R1 R7: first four bases fill segments in initial order, fifth evicts the first
        for (int r = 0; r < 5; r++) do_fetch(mk_pc(r, 3), 0);
        do_fetch(mk_pc(0, 3), 1);   // region 0 must now miss (R7)
        do_fetch(mk_pc(2, 3), 0);   // region 2 still resident

        // R6: fill a whole segment word by word, then sweep it again
        for (int w = 0; w < NWRD; w++) do_fetch(mk_pc(2, w), w % 3);
        for (int w = 0; w < NWRD; w++) do_fetch(mk_pc(2, w), 0);

        // R3: low counter bits ignored
        @(negedge clk);
        fetch_req = 1'b1;
        fetch_pc  = mk_pc(2, 17) | 32'hF;
        #1;
        chk(fetch_hit == 1'b1, "R3 hit with low bits set", 32'(fetch_hit), 32'd1);
        chk(fetch_word == mem_img(mk_pc(2, 17)), "R3 word with low bits set",
            32'(fetch_word), 32'(mem_img(mk_pc(2, 17))));
        do_fetch(mk_pc(4, 9) | 32'h5, 0);

        // R9: no request while idle, even for an absent word
        @(negedge clk);
        fetch_req = 1'b0;
        fetch_pc  = mk_pc(2, 5);
        #1;
        chk(fetch_hit == 1'b0, "R9 no hit while idle", 32'(fetch_hit), 32'd0);
        fetch_pc = mk_pc(5, 60);
        @(negedge clk);
        @(negedge clk);
        chk(mem_req == 1'b0, "R9 no refill while idle", 32'(mem_req), 32'd0);

        // R8: mixed sweep over six bases and eight words against four segments
        for (int n = 0; n < 900; n++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            do_fetch(mk_pc(int'((lcg >> 8) % 6), int'((lcg >> 16) % 8)), int'((lcg >> 28) % 3));
        end

        @(negedge clk);
        fetch_req = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule